// File: doc/BRIEF.md
# Event Timestamp Queue with Word-Serial Readout

This block keeps the event-timestamp queue for one direction of one port of a precision time protocol timestamping unit. When the capture logic finishes a timestamp, it raises a one-cycle strobe together with a full record. The record holds a 16-bit message tag, 48-bit seconds, 32-bit nanoseconds, a 64-bit clock identity, a 16-bit port number and a 16-bit sequence id. If capture is enabled and there is room, the record is stored in first-in, first-out order.

The host drains the queue through one 16-bit data port. Each read strobe consumes one word of the oldest record. A status word shows the enable bit, the current word position and a saturating count of events lost to a full queue. The block also drives this queue's bit of the shared buffer-status and interrupt-status words. It merges its interrupt bit with the shared mask to form an interrupt output. Parameters select the port index and the direction, and these place the status bits.

Top module: `ts_word_queue`

## Requirements
- R1: After reset the queue is empty and capture is disabled. The status word, buffer-status, interrupt-status, interrupt output and data word all read 0.
- R2: A capture strobe stores nothing while the enable (status bit 15) is clear. Such a strobe leaves the discard count unchanged.
- R3: A record reads out as 12 words from the data port. The order is tag (1 word), seconds (3), nanoseconds (2), clock identity (4), port number (1) and sequence id (1). Within each multi-word field the most significant word comes first. The low 3 bits of the tag carry the message type, and the tag is returned unchanged.
- R4: Status bits 12:8 hold the word position. The position is 0 before the tag word and rises by one per data read. After the 12th word it returns to 0, and at that point the record is removed.
- R5: Records leave the queue in the order in which they were captured.
- R6: The queue holds DEPTH (90) records. An enabled strobe that arrives while the queue is full is dropped. In that case the discard count in status bits 7:4 rises by one and stops at 15.
- R7: A data read from an empty queue returns 0 and leaves the word position unchanged.
- R8: A status write changes only the enable, which takes status-write bit 15. Writing 1 to status-write bit 0 clears the discard count, and all other written bits are ignored.
- R9: Buffer-status bit p (transmit) or bit p+3 (receive) is 1 while the queue holds a record, where p is the port index. All other bits are 0.
- R10: The interrupt-status bit, at the same position as the buffer-status bit, is 1 while the queue is non-empty and the enable is set. The interrupt output is that bit ANDed with the same bit of the mask input.
- R11: Clearing the enable keeps the records already stored, and they can still be read out in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_stb | input | 1 | One-cycle strobe for a completed record |
| cap_tag | input | 16 | Message tag, type in bits 2:0 |
| cap_sec | input | 48 | Seconds |
| cap_nsec | input | 32 | Nanoseconds |
| cap_clkid | input | 64 | Source clock identity |
| cap_portnum | input | 16 | Source port number |
| cap_seqid | input | 16 | Sequence id |
| stat_wr | input | 1 | Status write strobe |
| stat_wdata | input | 16 | Status write data |
| stat_rdata | output | 16 | Status word: enable, position, discard count |
| data_rd | input | 1 | Data read strobe; consumes the presented word |
| data_rdata | output | 16 | Current word of the oldest record |
| int_mask | input | 6 | Shared interrupt mask word |
| buf_stat | output | 6 | This queue's non-empty bit in the shared layout |
| int_stat | output | 6 | This queue's interrupt-status bit in the shared layout |
| irq | output | 1 | Masked interrupt |

## Verification
The bench targets the word boundary at the 12th read. A design with an off-by-one there would either leave the position stuck at 11 and repeat the sequence id, or pop one word early and start the next record at seconds. It fills the queue to exactly 90 records and then pushes 21 more strobes. An early full flag would lose the last record, and a discard count that wraps would read a small number instead of 15. The bench also reads an empty queue, to catch designs that advance the position anyway. It clears the enable while records are pending and then writes a word with only bit 0 set. A design that flushed on disable, or that let other status-write bits through, would either lose those records or show a changed status word.

// File: rtl/ts_word_queue.sv
module ts_word_queue #(
  parameter int DEPTH    = 90,
  parameter int PORT_IDX = 0,
  parameter bit IS_RX    = 1'b0,
  parameter int TAG_W    = 16,
  parameter int SEC_W    = 48,
  parameter int NSEC_W   = 32,
  parameter int CLK_W    = 64,
  parameter int PN_W     = 16,
  parameter int SEQ_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_stb,
  input  logic [TAG_W-1:0]  cap_tag,
  input  logic [SEC_W-1:0]  cap_sec,
  input  logic [NSEC_W-1:0] cap_nsec,
  input  logic [CLK_W-1:0]  cap_clkid,
  input  logic [PN_W-1:0]   cap_portnum,
  input  logic [SEQ_W-1:0]  cap_seqid,
  input  logic              stat_wr,
  input  logic [15:0]       stat_wdata,
  output logic [15:0]       stat_rdata,
  input  logic              data_rd,
  output logic [15:0]       data_rdata,
  input  logic [5:0]        int_mask,
  output logic [5:0]        buf_stat,
  output logic [5:0]        int_stat,
  output logic              irq
);
  localparam int REC_W   = TAG_W + SEC_W + NSEC_W + CLK_W + PN_W + SEQ_W;
  localparam int NWORDS  = REC_W / 16;
  localparam int PTR_W   = $clog2(DEPTH);
  localparam int CNT_W   = $clog2(DEPTH + 1);
  localparam int BIT_POS = PORT_IDX + (IS_RX ? 3 : 0);
  localparam logic [5:0] MY_BIT = 6'(1) << BIT_POS;
  localparam logic [3:0] DISC_MAX = 4'hF;

  logic [REC_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic [4:0]       pos;
  logic             en;
  logic [3:0]       disc;
  logic [REC_W-1:0] cur_rec;

  wire empty = (count == '0);
  wire full  = (count == CNT_W'(DEPTH));
  wire push  = cap_stb && en && !full;
  wire drop  = cap_stb && en && full;
  wire rd_ok = data_rd && !empty;
  wire pop   = rd_ok && (pos == 5'(NWORDS - 1));

  always_ff @(posedge clk)
    if (push) mem[wr_ptr] <= {cap_tag, cap_sec, cap_nsec, cap_clkid, cap_portnum, cap_seqid};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      pos    <= '0;
      en     <= 1'b0;
      disc   <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (pop)        pos <= '0;
      else if (rd_ok) pos <= pos + 1'b1;
      if (stat_wr) en <= stat_wdata[15];
      if (stat_wr && stat_wdata[0])    disc <= '0;
      else if (drop && disc != DISC_MAX) disc <= disc + 1'b1;
    end
  end

  assign cur_rec    = mem[rd_ptr];
  assign data_rdata = empty ? 16'h0 : cur_rec[(NWORDS - 1 - int'(pos)) * 16 +: 16];
  assign stat_rdata = {en, 2'b00, pos, disc, 4'h0};
  assign buf_stat   = empty ? 6'h0 : MY_BIT;
  assign int_stat   = (!empty && en) ? MY_BIT : 6'h0;
  assign irq        = |(int_stat & int_mask);
endmodule

// File: rtl/ts_word_queue_chk.sv
module ts_word_queue_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        data_rd,
  input logic        stat_wr,
  input logic [15:0] stat_wdata,
  input logic [15:0] stat_rdata,
  input logic [15:0] data_rdata,
  input logic [5:0]  int_mask,
  input logic [5:0]  buf_stat,
  input logic [5:0]  int_stat,
  input logic        irq
);
  // R4
  pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rdata[12:8] <= 5'd11);

  // R7
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && buf_stat == 6'h0) |=> $stable(stat_rdata[12:8]));

  // R7
  empty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_stat == 6'h0) |-> (data_rdata == 16'h0));

  // R6
  disc_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(stat_wr && stat_wdata[0]) |=> (stat_rdata[7:4] >= $past(stat_rdata[7:4])));

  // R10
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (stat_rdata[15] && ((int_stat & int_mask) != 6'h0)));

  // R2
  dis_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_rdata[15] && buf_stat == 6'h0) |=> (buf_stat == 6'h0));

  // R9
  onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(buf_stat));
endmodule

bind ts_word_queue ts_word_queue_chk u_chk (
  .clk(clk), .rst_n(rst_n), .data_rd(data_rd), .stat_wr(stat_wr),
  .stat_wdata(stat_wdata), .stat_rdata(stat_rdata), .data_rdata(data_rdata),
  .int_mask(int_mask), .buf_stat(buf_stat), .int_stat(int_stat), .irq(irq)
);

// File: tb/ts_word_queue_bench.sv
module ts_word_queue_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cap_stb = 1'b0;
  logic [15:0] cap_tag = '0;
  logic [47:0] cap_sec = '0;
  logic [31:0] cap_nsec = '0;
  logic [63:0] cap_clkid = '0;
  logic [15:0] cap_portnum = '0, cap_seqid = '0;
  logic stat_wr = 1'b0;
  logic [15:0] stat_wdata = '0;
  logic data_rd = 1'b0;
  logic [5:0] int_mask = '0;
  logic [15:0] stat_rdata, data_rdata;
  logic [5:0] buf_stat, int_stat;
  logic irq;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;
  logic [191:0] exp_q [$];
  bit en_m = 1'b0;
  int disc_m = 0;

  always #2 clk = ~clk;

  ts_word_queue #(.PORT_IDX(1), .IS_RX(1'b1)) u_ts_word_queue (.*);

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [191:0] mk(int i);
    return {16'(i % 5), 48'h1234_0000_0000 + 48'(i), 32'hA000_0000 + 32'(i * 3),
            64'hC0DE_0000_0000_0000 + 64'(i * 11), 16'(100 + i), 16'(i * 7)};
  endfunction

  task automatic capture(logic [191:0] r);
    @(negedge clk);
    {cap_tag, cap_sec, cap_nsec, cap_clkid, cap_portnum, cap_seqid} = r;
    cap_stb = 1'b1;
    if (en_m) begin
      if (exp_q.size() < 90) exp_q.push_back(r);
      else if (disc_m < 15) disc_m++;
    end
    @(negedge clk);
    cap_stb = 1'b0;
  endtask

  task automatic stat_write(logic [15:0] w);
    @(negedge clk);
    stat_wr = 1'b1; stat_wdata = w;
    en_m = w[15];
    if (w[0]) disc_m = 0;
    @(negedge clk);
    stat_wr = 1'b0;
  endtask

  task automatic read_word(output logic [15:0] w);
    @(negedge clk);
    w = data_rdata;
    data_rd = 1'b1;
    @(negedge clk);
    data_rd = 1'b0;
  endtask

  // monitor: pops the expected record and compares all 12 words
  task automatic pop_check(string req);
    logic [191:0] e;
    logic [15:0] w;
    e = exp_q.pop_front();
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      check("R4 position", 64'(stat_rdata[12:8]), 64'(k));
      read_word(w);
      check(req, 64'(w), 64'(e[191 - 16 * k -: 16]));
    end
    @(negedge clk);
    check("R4 position back to 0", 64'(stat_rdata[12:8]), 64'd0);
  endtask

  initial begin
    logic [15:0] w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 status", 64'(stat_rdata), 64'h0);
    check("R1 buf_stat", 64'(buf_stat), 64'h0);
    check("R1 int_stat", 64'(int_stat), 64'h0);
    check("R1 irq", 64'(irq), 64'h0);
    check("R1 data", 64'(data_rdata), 64'h0);

    capture(mk(50));
    @(negedge clk);
    check("R2 disabled capture buf_stat", 64'(buf_stat), 64'h0);
    check("R2 disabled capture discard", 64'(stat_rdata[7:4]), 64'h0);

    stat_write(16'h8000);
    @(negedge clk);
    check("R8 enable set", 64'(stat_rdata), 64'h8000);

    capture(mk(1));
    @(negedge clk);
    check("R9 buf_stat bit p+3", 64'(buf_stat), 64'h10);
    check("R10 int_stat", 64'(int_stat), 64'h10);
    int_mask = 6'h2F;
    @(negedge clk);
    check("R10 irq masked off", 64'(irq), 64'h0);
    int_mask = 6'h10;
    @(negedge clk);
    check("R10 irq unmasked", 64'(irq), 64'h1);
    pop_check("R3 word order");
    check("R9 empty after pop", 64'(buf_stat), 64'h0);

    read_word(w);
    check("R7 empty read data", 64'(w), 64'h0);
    @(negedge clk);
    check("R7 empty read position", 64'(stat_rdata[12:8]), 64'h0);

    for (int i = 2; i < 5; i++) capture(mk(i));
    for (int i = 0; i < 3; i++) pop_check("R5 order");

    capture(mk(9));
    stat_write(16'h7FFE);
    @(negedge clk);
    check("R8 other bits ignored", 64'(stat_rdata), 64'h0);
    check("R11 buf_stat kept", 64'(buf_stat), 64'h10);
    check("R10 int_stat off when disabled", 64'(int_stat), 64'h0);
    check("R10 irq off when disabled", 64'(irq), 64'h0);
    pop_check("R11 readout while disabled");

    stat_write(16'h8000);
    for (int i = 0; i < 90; i++) capture(mk(200 + i));
    @(negedge clk);
    check("R6 no discard at 90", 64'(stat_rdata[7:4]), 64'h0);
    capture(mk(999));
    @(negedge clk);
    check("R6 discard on full", 64'(stat_rdata[7:4]), 64'h1);
    for (int i = 0; i < 20; i++) capture(mk(1000 + i));
    @(negedge clk);
    check("R6 discard saturates", 64'(stat_rdata[7:4]), 64'(disc_m));
    check("R6 discard is 15", 64'(disc_m), 64'd15);
    while (exp_q.size() > 0) pop_check("R6 R5 full queue contents");
    check("R6 drained", 64'(buf_stat), 64'h0);

    stat_write(16'h0001);
    @(negedge clk);
    check("R8 discard cleared, enable off", 64'(stat_rdata), 64'h0);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 200000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=running expected=done");
    end
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule